// File: doc/BRIEF.md
# Stream Handshake Profiling Counters

This block sits beside one valid/ready stream and watches it without driving anything on it. Six running counters build up while the enable input is high. The first sums the per-beat element count of every completed handshake. The second counts cycles with valid high. The third counts cycles with ready high. The fourth counts completed handshakes. The fifth counts handshakes that close a packet. The sixth counts enabled clock cycles. A multi-element stream can therefore add more than one element per beat.

Software that has read a counter can deduct what it read through a subtract-on-write port. The write names a counter and a value, and the block takes that value off the counter instead of overwriting it. Increments that land in the same cycle are not lost. The cycle counter does not take part in subtraction. A clear input returns every counter to zero. All counters wrap modulo 2^OUT_W.

Top module: `stream_prof_counters`

## Requirements
- R1: After reset every one of the six count outputs reads zero.
- R2: While enable is high, the element counter adds the zero-extended probe_count on each cycle with probe_valid and probe_ready both high, including a count of zero.
- R3: While enable is high, the valid counter adds one on each cycle with probe_valid high, whatever probe_ready is.
- R4: While enable is high, the ready counter adds one on each cycle with probe_ready high, whatever probe_valid is.
- R5: While enable is high, the transfer counter adds one on each cycle with probe_valid and probe_ready both high.
- R6: While enable is high, the packet counter adds one on each handshake cycle in which probe_last is high, and on no other cycle.
- R7: The cycle counter adds one on every clock edge at which enable is high.
- R8: With enable low, probe activity changes no counter.
- R9: A clear at a clock edge sets all six counters to zero, with priority over any increment or subtract at that edge.
- R10: With sub_we high, sub_sel selects the target: 0 elements, 1 valids, 2 readies, 3 transfers, 4 packets. The target's next value is old + increment - sub_val, and the subtract applies whether or not enable is high.
- R11: A subtract write with sub_sel of 5, 6 or 7 changes no counter beyond its normal increment.
- R12: All counters wrap modulo 2^OUT_W on overflow and underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_valid | input | 1 | Observed stream valid |
| probe_ready | input | 1 | Observed stream ready |
| probe_last | input | 1 | Observed stream end-of-packet marker |
| probe_count | input | CNT_IN_W | Elements carried by the current beat |
| enable | input | 1 | Counting enable |
| clear | input | 1 | Synchronous zeroing of all counters |
| sub_we | input | 1 | Subtract write strobe |
| sub_sel | input | 3 | Subtract target code (see R10) |
| sub_val | input | OUT_W | Amount to subtract |
| cnt_elem | output | OUT_W | Element counter |
| cnt_valid | output | OUT_W | Valid-cycle counter |
| cnt_ready | output | OUT_W | Ready-cycle counter |
| cnt_xfer | output | OUT_W | Handshake counter |
| cnt_pkt | output | OUT_W | Packet counter |
| cnt_cyc | output | OUT_W | Enabled-cycle counter |

## Verification
A subtract write and a stream increment can hit the same counter in the same cycle. The bench provokes this by driving a handshake, with a non-zero element count and last high, at the same edge as a write to each subtractable counter. It expects old plus increment minus written value. Clear is also driven together with both a handshake and a subtract, and every counter must read zero afterwards. An underflowing subtract followed by an increment shows the wrap in both directions.

// File: rtl/stream_prof_pkg.sv
package stream_prof_pkg;

   localparam int N_CNT   = 6;
   localparam int SEL_W   = 3;

   // Counter codes; order matters, it is the sub_sel encoding.
   typedef enum logic [SEL_W-1:0] {
      SEL_ELEM  = 3'd0,
      SEL_VALID = 3'd1,
      SEL_READY = 3'd2,
      SEL_XFER  = 3'd3,
      SEL_PKT   = 3'd4,
      SEL_CYC   = 3'd5
   } prof_sel_e;

   // Counters that accept a subtract write: all below the cycle counter.
   localparam int N_SUB = int'(SEL_CYC);

endpackage

// File: rtl/prof_event_decode.sv
module prof_event_decode
   import stream_prof_pkg::*;
#(
   parameter int CNT_IN_W = 1,
   parameter int OUT_W    = 32
) (
   input  logic                           valid,
   input  logic                           ready,
   input  logic                           last,
   input  logic [CNT_IN_W-1:0]            count,
   input  logic                           enable,
   output logic [N_CNT-1:0][OUT_W-1:0]    incr
);

   logic hs;

   always_comb begin
      hs = valid & ready;
      incr = '0;
      if (enable) begin
         incr[SEL_ELEM]  = hs ? OUT_W'(count) : '0;
         incr[SEL_VALID] = OUT_W'(valid);
         incr[SEL_READY] = OUT_W'(ready);
         incr[SEL_XFER]  = OUT_W'(hs);
         incr[SEL_PKT]   = OUT_W'(hs & last);
         incr[SEL_CYC]   = OUT_W'(1'b1);
      end
   end

endmodule

// File: rtl/prof_sub_decode.sv
module prof_sub_decode
   import stream_prof_pkg::*;
(
   input  logic             sub_we,
   input  logic [SEL_W-1:0] sub_sel,
   output logic [N_CNT-1:0] sub_hit
);

   genvar gi;
   generate
      for (gi = 0; gi < N_CNT; gi++) begin : g_hit
         if (gi < N_SUB) begin : g_sub
            assign sub_hit[gi] = sub_we && (sub_sel == SEL_W'(gi));
         end else begin : g_nosub
            assign sub_hit[gi] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/prof_counter.sv
module prof_counter #(
   parameter int W       = 32,
   parameter bit HAS_SUB = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic [W-1:0] inc,
   input  logic         sub_hit,
   input  logic [W-1:0] sub_val,
   output logic [W-1:0] cnt
);

   logic [W-1:0] nxt;

   generate
      if (HAS_SUB) begin : g_sub
         assign nxt = cnt + inc - (sub_hit ? sub_val : '0);
      end else begin : g_plain
         logic unused_sub;
         assign unused_sub = sub_hit ^ (^sub_val);
         assign nxt = cnt + inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else            cnt <= nxt;
   end

endmodule

// File: rtl/stream_prof_counters.sv
module stream_prof_counters
   import stream_prof_pkg::*;
#(
   parameter int CNT_IN_W = 1,
   parameter int OUT_W    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                probe_valid,
   input  logic                probe_ready,
   input  logic                probe_last,
   input  logic [CNT_IN_W-1:0] probe_count,
   input  logic                enable,
   input  logic                clear,
   input  logic                sub_we,
   input  logic [2:0]          sub_sel,
   input  logic [OUT_W-1:0]    sub_val,
   output logic [OUT_W-1:0]    cnt_elem,
   output logic [OUT_W-1:0]    cnt_valid,
   output logic [OUT_W-1:0]    cnt_ready,
   output logic [OUT_W-1:0]    cnt_xfer,
   output logic [OUT_W-1:0]    cnt_pkt,
   output logic [OUT_W-1:0]    cnt_cyc
);

   generate
      if (CNT_IN_W < 1) begin : g_bad_in_w
         $error("CNT_IN_W must be at least 1");
      end
      if (OUT_W < CNT_IN_W || OUT_W < 2) begin : g_bad_out_w
         $error("OUT_W must be at least 2 and no narrower than CNT_IN_W");
      end
   endgenerate

   logic [N_CNT-1:0][OUT_W-1:0] incr;
   logic [N_CNT-1:0]            sub_hit;
   logic [N_CNT-1:0][OUT_W-1:0] cnt_q;

   prof_event_decode #(
      .CNT_IN_W (CNT_IN_W),
      .OUT_W    (OUT_W)
   ) u_evt (
      .valid  (probe_valid),
      .ready  (probe_ready),
      .last   (probe_last),
      .count  (probe_count),
      .enable (enable),
      .incr   (incr)
   );

   prof_sub_decode u_sub (
      .sub_we  (sub_we),
      .sub_sel (sub_sel),
      .sub_hit (sub_hit)
   );

   genvar gi;
   generate
      for (gi = 0; gi < N_CNT; gi++) begin : g_cnt
         prof_counter #(
            .W       (OUT_W),
            .HAS_SUB (gi < N_SUB)
         ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .inc     (incr[gi]),
            .sub_hit (sub_hit[gi]),
            .sub_val (sub_val),
            .cnt     (cnt_q[gi])
         );
      end
   endgenerate

   assign cnt_elem  = cnt_q[SEL_ELEM];
   assign cnt_valid = cnt_q[SEL_VALID];
   assign cnt_ready = cnt_q[SEL_READY];
   assign cnt_xfer  = cnt_q[SEL_XFER];
   assign cnt_pkt   = cnt_q[SEL_PKT];
   assign cnt_cyc   = cnt_q[SEL_CYC];

endmodule

// File: rtl/stream_prof_chk.sv
module stream_prof_chk #(
   parameter int CNT_IN_W = 1,
   parameter int OUT_W    = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                probe_valid,
   input logic                probe_ready,
   input logic                probe_last,
   input logic [CNT_IN_W-1:0] probe_count,
   input logic                enable,
   input logic                clear,
   input logic                sub_we,
   input logic [2:0]          sub_sel,
   input logic [OUT_W-1:0]    sub_val,
   input logic [OUT_W-1:0]    cnt_elem,
   input logic [OUT_W-1:0]    cnt_valid,
   input logic [OUT_W-1:0]    cnt_ready,
   input logic [OUT_W-1:0]    cnt_xfer,
   input logic [OUT_W-1:0]    cnt_pkt,
   input logic [OUT_W-1:0]    cnt_cyc
);

   logic no_sub_valid, no_sub_pkt, no_sub_elem;
   assign no_sub_valid = !(sub_we && sub_sel == 3'd1);
   assign no_sub_pkt   = !(sub_we && sub_sel == 3'd4);
   assign no_sub_elem  = !(sub_we && sub_sel == 3'd0);

   a_r3_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
      enable && !clear && no_sub_valid |=>
         cnt_valid == OUT_W'($past(cnt_valid) + OUT_W'($past(probe_valid))));

   a_r2_elem_step: assert property (@(posedge clk) disable iff (!rst_n)
      enable && !clear && no_sub_elem && probe_valid && probe_ready |=>
         cnt_elem == OUT_W'($past(cnt_elem) + OUT_W'($past(probe_count))));

   a_r6_pkt_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(probe_valid && probe_ready && probe_last) && !clear && no_sub_pkt |=>
         $stable(cnt_pkt));

   a_r7_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
      enable && !clear |=> cnt_cyc == OUT_W'($past(cnt_cyc) + 1'b1));

   a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !enable && !clear && !sub_we |=>
         $stable(cnt_elem) && $stable(cnt_valid) && $stable(cnt_ready) &&
         $stable(cnt_xfer) && $stable(cnt_pkt) && $stable(cnt_cyc));

   a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cnt_elem == '0 && cnt_valid == '0 && cnt_ready == '0 &&
                cnt_xfer == '0 && cnt_pkt == '0 && cnt_cyc == '0);

   a_r11_bad_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !enable && !clear && sub_we && sub_sel >= 3'd5 |=>
         $stable(cnt_elem) && $stable(cnt_valid) && $stable(cnt_ready) &&
         $stable(cnt_xfer) && $stable(cnt_pkt) && $stable(cnt_cyc));

endmodule

bind stream_prof_counters stream_prof_chk #(
   .CNT_IN_W (CNT_IN_W),
   .OUT_W    (OUT_W)
) u_chk (.*);

// File: tb/stream_prof_counters_tb.sv
`timescale 1ns/1ps
module stream_prof_counters_tb;

   localparam int IW = 3;
   localparam int OW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pv = 0, pr = 0, pl = 0;
   logic [IW-1:0] pc = '0;
   logic          en = 0, clr = 0, we = 0;
   logic [2:0]    sel = '0;
   logic [OW-1:0] val = '0;
   logic [OW-1:0] c_elem, c_valid, c_ready, c_xfer, c_pkt, c_cyc;

   always #10 clk = ~clk;

   stream_prof_counters #(.CNT_IN_W(IW), .OUT_W(OW)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .probe_valid(pv), .probe_ready(pr), .probe_last(pl), .probe_count(pc),
      .enable(en), .clear(clr),
      .sub_we(we), .sub_sel(sel), .sub_val(val),
      .cnt_elem(c_elem), .cnt_valid(c_valid), .cnt_ready(c_ready),
      .cnt_xfer(c_xfer), .cnt_pkt(c_pkt), .cnt_cyc(c_cyc)
   );

   typedef struct {
      logic [5:0][OW-1:0] c;
      string              tag;
   } exp_t;

   exp_t               q[$];
   logic [5:0][OW-1:0] model = '0;
   int                 n_cmp = 0;
   int                 n_bad = 0;
   bit                 done = 0;

   // Driver: applies one cycle of stimulus and queues the expected counters.
   task automatic step(input logic v, input logic r, input logic l,
                       input logic [IW-1:0] n, input logic e, input logic c,
                       input logic w, input logic [2:0] s,
                       input logic [OW-1:0] x, input string tag);
      logic [5:0][OW-1:0] inc;
      exp_t it;
      @(negedge clk);
      pv = v; pr = r; pl = l; pc = n; en = e; clr = c; we = w; sel = s; val = x;
      inc = '0;
      if (e) begin
         inc[0] = (v && r) ? OW'(n) : '0;
         inc[1] = OW'(v);
         inc[2] = OW'(r);
         inc[3] = OW'(v && r);
         inc[4] = OW'(v && r && l);
         inc[5] = 1;
      end
      for (int i = 0; i < 6; i++) begin
         if (c) model[i] = '0;
         else model[i] = model[i] + inc[i] - ((w && s == 3'(i) && i < 5) ? x : '0);
      end
      @(posedge clk);
      #1;
      it.c = model;
      it.tag = tag;
      q.push_back(it);
   endtask

   // Monitor: compares the design against the queued expectations.
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t it;
         logic [5:0][OW-1:0] got;
         it = q.pop_front();
         got = {c_cyc, c_pkt, c_xfer, c_ready, c_valid, c_elem};
         for (int i = 0; i < 6; i++) begin
            n_cmp++;
            if (got[i] !== it.c[i]) begin
               n_bad++;
               $display("FAIL %s counter %0d: actual=%h expected=%h", it.tag, i, got[i], it.c[i]);
            end
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      step(0,0,0,0, 0,0,0,0,0, "R1 reset state");
      // R3, R4, R7: one-sided valid and ready
      step(1,0,0,5, 1,0,0,0,0, "R3 valid only");
      step(1,0,1,5, 1,0,0,0,0, "R3 valid only last");
      step(0,1,0,5, 1,0,0,0,0, "R4 ready only");
      step(0,0,0,0, 1,0,0,0,0, "R7 idle enabled");
      // R2, R5, R6: handshakes with multi-element beats
      step(1,1,0,3, 1,0,0,0,0, "R2 R5 handshake 3");
      step(1,1,1,7, 1,0,0,0,0, "R6 packet end 7");
      step(1,1,1,0, 1,0,0,0,0, "R2 zero-count beat");
      step(1,1,0,1, 1,0,0,0,0, "R5 handshake 1");
      // R8: disabled with activity
      step(1,1,1,6, 0,0,0,0,0, "R8 disabled handshake");
      step(1,0,0,2, 0,0,0,0,0, "R8 disabled valid");
      // R10: subtract colliding with increments
      step(1,1,1,4, 1,0,1,0,2, "R10 sub elem with beat");
      step(1,1,1,4, 1,0,1,1,1, "R10 sub valid with beat");
      step(1,1,1,4, 1,0,1,2,2, "R10 sub ready with beat");
      step(1,1,1,4, 1,0,1,3,1, "R10 sub xfer with beat");
      step(1,1,1,4, 1,0,1,4,2, "R10 sub pkt with beat");
      step(0,0,0,0, 0,0,1,0,1, "R10 sub elem while disabled");
      // R11: non-subtractable codes
      step(1,1,0,2, 1,0,1,5,7, "R11 sub cycle code");
      step(0,0,0,0, 0,0,1,6,3, "R11 sub code 6");
      step(0,0,0,0, 0,0,1,7,3, "R11 sub code 7");
      // R12: underflow then overflow back through zero
      step(0,0,0,0, 1,0,1,1,32'h0000_00ff, "R12 underflow valid");
      step(1,0,0,0, 1,0,0,0,0, "R12 count up");
      step(0,0,0,0, 0,0,1,4,c_pkt + 1, "R12 pkt to all ones");
      step(1,1,1,1, 1,0,0,0,0, "R12 pkt wraps to zero");
      // R9: clear beats increment and subtract
      step(1,1,1,5, 1,1,1,0,1, "R9 clear with beat and sub");
      step(1,1,0,2, 1,0,0,0,0, "R9 count after clear");
      step(0,0,0,0, 0,1,0,0,0, "R9 clear while disabled");
      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule